// File: doc/BRIEF.md
# Stereo Serial Audio Port with Clock Master/Slave Mode

This block moves stereo sample pairs between a parallel on-chip interface and a three-wire serial audio link. The link has a bit clock, a word-select clock (low for the left slot, high for the right slot) and one serial data line in each direction. With the mode input set to master, the port divides the system clock to make the bit clock and builds a 64-bit-clock frame from it. With the mode input clear, both clocks come from the far end. They are brought into the system-clock domain before their edges are used.

Data travels MSB first, starting one bit clock after each word-select change. The word length is 16, 20, 24 or 32 bits, and unused trailing bit positions carry zeros. Serial outputs change on the falling bit-clock edge. The serial input and the word-select level are sampled on the rising edge.

At the start of each frame, a one-cycle strobe shows that a new transmit pair has been latched. A second one-cycle strobe shows that a complete received left/right pair is on the receive outputs.

Top module: `aud_serial_port`

## Requirements
- R1: With `master` high, the port drives `sck_out` and `ws_out`. With `master` low, both stay 0, and framing follows `sck_in` and `ws_in`.
- R2: In master mode, the `sck_out` period is 2*max(`sck_half`,1) system-clock cycles, with equal high and low times.
- R3: In master mode, a frame is 64 bit clocks long. `ws_out` is low for 32 bit clocks (left slot) and high for 32 bit clocks (right slot), and it changes only in the cycle where `sck_out` falls.
- R4: `sd_out` changes only on falling bit-clock edges. A slot word is sent MSB first, and its MSB is the bit sampled at the second rising edge after the word-select change, which gives a one-bit delay.
- R5: `wlen_sel` selects the word length: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits. Bits of `tx_left`/`tx_right` below the word length (bit 31 is the MSB) are sent as zero.
- R6: `sd_in` is captured on rising bit-clock edges in both modes, using the same framing as R4. Each received word appears left-justified in 32 bits, with zeros below the word length.
- R7: `rx_valid` is a one-cycle pulse. It rises after the right word of a frame whose left word was also received, and it presents that left/right pair on `rx_left`/`rx_right`.
- R8: `tx_load` is a one-cycle pulse. It rises just after `tx_left`/`tx_right` are latched at the rising edge where word-select is first seen low. The latched pair is sent in the frame that starts there.
- R9: In slave mode, with `sck_in` half-periods of at least 4 system-clock cycles, both directions follow R4 to R7. The external clocks pass through a two-flop synchroniser first.
- R10: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 x sample rate) |
| rst | input | 1 | Synchronous active-high reset |
| master | input | 1 | 1 = generate clocks, 0 = accept external clocks |
| sck_half | input | DIV_W | Bit-clock half period in system-clock cycles (0 treated as 1) |
| wlen_sel | input | 2 | Word length select (16/20/24/32) |
| tx_left | input | 32 | Left transmit sample, MSB at bit 31 |
| tx_right | input | 32 | Right transmit sample, MSB at bit 31 |
| tx_load | output | 1 | Pulse: transmit pair latched for this frame |
| rx_left | output | 32 | Left received sample, left-justified |
| rx_right | output | 32 | Right received sample, left-justified |
| rx_valid | output | 1 | Pulse: new received pair on rx_left/rx_right |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word-select clock (slave mode) |
| sd_in | input | 1 | Serial receive data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word-select clock (master mode) |
| sd_out | output | 1 | Serial transmit data |

## Verification
The hardest case to reach is a 32-bit word. Its LSB lands exactly on the bit period in which word-select toggles, so transmit and receive must finish one word and begin the next on the same edge. This is hardest at the smallest divider, where rising and falling events occur on consecutive system-clock cycles. The bench ties `sd_out` back to `sd_in` and runs master mode at divider values 1, 2 and 3 across all word lengths. It then runs slave mode with a bench-generated clock, where the synchroniser delay sits between the external edges and the data. A serial decoder on the bench side checks the wire format independently of the receive path.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int unsigned SLOT_W  = 32;
  localparam int unsigned FRAME_W = 2 * SLOT_W;
  localparam int unsigned BITCNT_W = $clog2(FRAME_W);
  localparam int unsigned LEN_W   = $clog2(SLOT_W) + 1;

  typedef enum logic [1:0] {WL16 = 2'd0, WL20 = 2'd1, WL24 = 2'd2, WL32 = 2'd3} wlen_e;

  function automatic logic [LEN_W-1:0] wlen_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WL16:    return LEN_W'(16);
      WL20:    return LEN_W'(20);
      WL24:    return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  // keeps the top wlen_bits bits of a slot word
  function automatic logic [SLOT_W-1:0] wlen_mask(input logic [1:0] sel);
    return ~({SLOT_W{1'b1}} >> wlen_bits(sel));
  endfunction
endpackage

// File: rtl/aud_sck_gen.sv
module aud_sck_gen
  import aud_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             ws,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0]    cnt;
  logic [DIV_W-1:0]    lim;
  logic [BITCNT_W-1:0] bitcnt;
  logic [BITCNT_W-1:0] bitnext;
  logic                wrap;

  assign lim     = (half == '0) ? '0 : half - DIV_W'(1);
  assign wrap    = en && (cnt >= lim);
  assign rise_ev = wrap && !sck;
  assign fall_ev = wrap && sck;
  assign bitnext = bitcnt + BITCNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt    <= '0;
      sck    <= 1'b0;
      ws     <= 1'b0;
      bitcnt <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + DIV_W'(1);
      if (wrap) sck <= ~sck;
      if (fall_ev) begin
        bitcnt <= bitnext;
        ws     <= bitnext[BITCNT_W-1];
      end
    end
  end
endmodule

// File: rtl/aud_slave_sync.sv
module aud_slave_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic rise_ev,
  output logic fall_ev,
  output logic ws,
  output logic sd
);
  logic [STAGES-1:0] s_sck, s_ws, s_sd;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_sck    <= '0;
      s_ws     <= '0;
      s_sd     <= '0;
      sck_prev <= 1'b0;
    end else begin
      s_sck    <= {s_sck[STAGES-2:0], sck_in};
      s_ws     <= {s_ws[STAGES-2:0], ws_in};
      s_sd     <= {s_sd[STAGES-2:0], sd_in};
      sck_prev <= s_sck[STAGES-1];
    end
  end

  assign rise_ev = s_sck[STAGES-1] && !sck_prev;
  assign fall_ev = !s_sck[STAGES-1] && sck_prev;
  assign ws      = s_ws[STAGES-1];
  assign sd      = s_sd[STAGES-1];
endmodule

// File: rtl/aud_tx.sv
module aud_tx
  import aud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        wlen_sel,
  input  logic              slot_start,
  input  logic              new_ws,
  input  logic              fall_ev,
  input  logic [SLOT_W-1:0] tx_left,
  input  logic [SLOT_W-1:0] tx_right,
  output logic              tx_load,
  output logic              sd_out
);
  logic [SLOT_W-1:0] hold_l, hold_r, sh, word;
  logic              pend, pend_side;

  assign word = pend_side ? hold_r : hold_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l    <= '0;
      hold_r    <= '0;
      sh        <= '0;
      pend      <= 1'b0;
      pend_side <= 1'b0;
      tx_load   <= 1'b0;
      sd_out    <= 1'b0;
    end else begin
      tx_load <= slot_start && !new_ws;
      if (slot_start) begin
        pend      <= 1'b1;
        pend_side <= new_ws;
        if (!new_ws) begin
          hold_l <= tx_left & wlen_mask(wlen_sel);
          hold_r <= tx_right & wlen_mask(wlen_sel);
        end
      end
      if (fall_ev) begin
        if (pend) begin
          sd_out <= word[SLOT_W-1];
          sh     <= word << 1;
          pend   <= 1'b0;
        end else begin
          sd_out <= sh[SLOT_W-1];
          sh     <= sh << 1;
        end
      end
    end
  end

  p_load_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> !tx_load);
endmodule

// File: rtl/aud_rx.sv
module aud_rx
  import aud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        wlen_sel,
  input  logic              rise_ev,
  input  logic              slot_start,
  input  logic              new_ws,
  input  logic              sd,
  output logic [SLOT_W-1:0] rx_left,
  output logic [SLOT_W-1:0] rx_right,
  output logic              rx_valid
);
  logic [SLOT_W-1:0] sh, sh_n, stage_l, word;
  logic [LEN_W-1:0]  cnt, cnt_n, nb;
  logic              side, synced, left_got, acc, done;

  assign nb    = wlen_bits(wlen_sel);
  assign acc   = synced && (cnt < nb);
  assign sh_n  = acc ? {sh[SLOT_W-2:0], sd} : sh;
  assign cnt_n = cnt + LEN_W'(acc);
  assign done  = acc && (cnt_n == nb);
  assign word  = sh_n << (LEN_W'(SLOT_W) - nb);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      cnt      <= '0;
      side     <= 1'b0;
      synced   <= 1'b0;
      left_got <= 1'b0;
      stage_l  <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_ev) begin
        if (done) begin
          if (!side) begin
            stage_l  <= word;
            left_got <= 1'b1;
          end else if (left_got) begin
            rx_left  <= stage_l;
            rx_right <= word;
            rx_valid <= 1'b1;
            left_got <= 1'b0;
          end
        end
        if (slot_start) begin
          cnt    <= '0;
          sh     <= '0;
          side   <= new_ws;
          synced <= 1'b1;
        end else begin
          cnt <= cnt_n;
          sh  <= sh_n;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_valid_after_rise_r6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(rise_ev));
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
  import aud_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic [DIV_W-1:0]  sck_half,
  input  logic [1:0]        wlen_sel,
  input  logic [SLOT_W-1:0] tx_left,
  input  logic [SLOT_W-1:0] tx_right,
  output logic              tx_load,
  output logic [SLOT_W-1:0] rx_left,
  output logic [SLOT_W-1:0] rx_right,
  output logic              rx_valid,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              sck_out,
  output logic              ws_out,
  output logic              sd_out
);
  logic m_rise, m_fall;
  logic s_rise, s_fall, s_ws, s_sd;
  logic rise_ev, fall_ev, ws_smp, sd_smp;
  logic ws_prev, slot_start;

  aud_sck_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst(rst), .en(master), .half(sck_half),
    .sck(sck_out), .ws(ws_out), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  aud_slave_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .rise_ev(s_rise), .fall_ev(s_fall), .ws(s_ws), .sd(s_sd)
  );

  assign rise_ev = master ? m_rise : s_rise;
  assign fall_ev = master ? m_fall : s_fall;
  assign ws_smp  = master ? ws_out : s_ws;
  assign sd_smp  = master ? sd_in  : s_sd;

  // a slot begins at the rising edge that first sees a new word-select level
  assign slot_start = rise_ev && (ws_smp != ws_prev);

  always_ff @(posedge clk) begin
    if (rst) ws_prev <= 1'b0;
    else if (rise_ev) ws_prev <= ws_smp;
  end

  aud_tx u_tx (
    .clk(clk), .rst(rst), .wlen_sel(wlen_sel), .slot_start(slot_start),
    .new_ws(ws_smp), .fall_ev(fall_ev), .tx_left(tx_left), .tx_right(tx_right),
    .tx_load(tx_load), .sd_out(sd_out)
  );

  aud_rx u_rx (
    .clk(clk), .rst(rst), .wlen_sel(wlen_sel), .rise_ev(rise_ev),
    .slot_start(slot_start), .new_ws(ws_smp), .sd(sd_smp),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  p_ws_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (master && $past(master) && ws_out != $past(ws_out)) |-> $fell(sck_out));
  p_sd_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
    (master && $past(master) && sd_out != $past(sd_out)) |-> $fell(sck_out));
  p_slave_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!master && !$past(master)) |-> (!sck_out && !ws_out));
endmodule

// File: tb/tb_aud_serial_port.sv
module tb_aud_serial_port;
  logic        clk = 0, rst = 1, master = 1;
  logic [7:0]  sck_half = 8'd2;
  logic [1:0]  wlen_sel = 2'd3;
  logic [31:0] tx_left = 0, tx_right = 0;
  logic        sck_in = 0, ws_in = 0;
  logic        tx_load, rx_valid, sck_out, ws_out, sd_out, sd_in;
  logic [31:0] rx_left, rx_right;

  int checks = 0, errors = 0, cyc = 0, k = 0, n_rx = 0, n_ser = 0;
  logic [31:0] q_l[$], q_r[$], q_s[$];
  bit d_on = 0, d_ws = 0, quiet_bad = 0;
  int d_n = 0;
  logic [31:0] d_w = 0;

  assign sd_in = sd_out; // loopback

  aud_serial_port dut (
    .clk(clk), .rst(rst), .master(master), .sck_half(sck_half), .wlen_sel(wlen_sel),
    .tx_left(tx_left), .tx_right(tx_right), .tx_load(tx_load),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid),
    .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [1:0] w);
    case (w) 2'd0: return 32'hFFFF_0000; 2'd1: return 32'hFFFF_F000;
      2'd2: return 32'hFFFF_FF00; default: return 32'hFFFF_FFFF; endcase
  endfunction

  task automatic present(input int i);
    tx_left  = 32'h8000_0001 ^ (i * 32'h9E37_79B9);
    tx_right = ~tx_left ^ (i << 3);
  endtask

  // driver: each latched pair becomes an expectation
  always @(negedge clk) if (!rst && tx_load) begin
    q_l.push_back(tx_left & mask(wlen_sel));
    q_r.push_back(tx_right & mask(wlen_sel));
    q_s.push_back(tx_left & mask(wlen_sel));
    q_s.push_back(tx_right & mask(wlen_sel));
    k++;
    present(k);
  end

  // monitor: received pairs (R6, R7)
  always @(negedge clk) if (!rst && rx_valid) begin
    if (q_l.size() == 0) chk(0, "R7", "rx_valid with no pair pending", 32'd1, 32'd0);
    else begin
      logic [31:0] el, er;
      el = q_l.pop_front(); er = q_r.pop_front();
      chk(rx_left == el, "R6", "rx_left", rx_left, el);
      chk(rx_right == er, "R6", "rx_right", rx_right, er);
      n_rx++;
    end
  end

  // wire decoder: MSB first, one-bit delay (R4, R5)
  wire s_clk = master ? sck_out : sck_in;
  wire s_ws  = master ? ws_out : ws_in;
  always @(posedge s_clk) if (!rst) begin
    if (d_on && d_n < 32) begin
      d_w = {d_w[30:0], sd_out};
      d_n++;
      if (d_n == 32) begin
        if (q_s.size() == 0) chk(0, "R4", "serial word with none expected", d_w, 32'd0);
        else begin
          logic [31:0] e;
          e = q_s.pop_front();
          chk(d_w == e, "R4", "serial word", d_w, e);
          n_ser++;
        end
      end
    end
    if (s_ws != d_ws) begin
      if (!s_ws) d_on = 1;
      d_n = 0; d_w = 0;
    end
    d_ws = s_ws;
  end

  always @(posedge clk) begin
    cyc++;
    if (!rst && !master && (sck_out || ws_out)) quiet_bad = 1;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic slave_frames(input int frames, input int h);
    for (int f = 0; f < frames; f++)
      for (int b = 0; b < 64; b++) begin
        @(negedge clk); sck_in = 0; ws_in = (b >= 32);
        repeat (h - 1) @(negedge clk);
        @(negedge clk); sck_in = 1;
        repeat (h - 1) @(negedge clk);
      end
  endtask

  task automatic run_phase(input bit m, input int h, input logic [1:0] w, input int frames);
    int b_rx, b_ser, t0;
    rst = 1; master = m; sck_half = 8'(h); wlen_sel = w;
    sck_in = 0; ws_in = 0;
    q_l.delete(); q_r.delete(); q_s.delete();
    d_on = 0; d_ws = 0; d_n = 0; k = 0; present(0); quiet_bad = 0;
    repeat (4) @(negedge clk);
    chk({tx_load, rx_valid, sck_out, ws_out, sd_out} == 5'b0 && rx_left == 0 && rx_right == 0,
        "R10", "outputs in reset", {27'd0, tx_load, rx_valid, sck_out, ws_out, sd_out}, 32'd0);
    rst = 0; b_rx = n_rx; b_ser = n_ser;
    if (m) begin
      @(posedge sck_out); t0 = cyc; @(posedge sck_out);
      chk(cyc - t0 == 2 * h, "R2", "bit clock period", cyc - t0, 2 * h);
      @(posedge ws_out); t0 = cyc; @(negedge ws_out);
      chk(cyc - t0 == 64 * h, "R3", "right slot length", cyc - t0, 64 * h);
      repeat (frames * 128 * h) @(negedge clk);
    end else begin
      slave_frames(frames, h);
      chk(!quiet_bad, "R1", "clock outputs quiet in slave mode", 32'(quiet_bad), 0);
    end
    chk(n_rx - b_rx >= frames - 3, "R7", "received pair count", n_rx - b_rx, frames - 3);
    chk(n_ser - b_ser >= 2 * (frames - 3), "R5", "decoded word count", n_ser - b_ser, 2 * (frames - 3));
    chk(k >= frames - 3, "R8", "tx_load count", k, frames - 3);
  endtask

  initial begin
    run_phase(1, 2, 2'd3, 8);   // R2 R3 256fs divider, 32-bit
    run_phase(1, 3, 2'd0, 8);   // R5 16-bit zero fill
    run_phase(1, 2, 2'd1, 8);   // R5 20-bit
    run_phase(1, 1, 2'd2, 8);   // R2 shortest bit clock, 24-bit
    run_phase(0, 8, 2'd3, 7);   // R9 R1 slave, 32-bit
    run_phase(0, 4, 2'd0, 7);   // R9 slave, 16-bit, minimum half period
    rst = 1; repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule